// File: doc/BRIEF.md
# CPU Power Domain Shutdown Sequencer

This block is a hardware state machine that turns off up to three secondary CPU power domains without software stepping through each register write. A one-cycle start pulse arrives with a domain mask. The sequencer then writes a one-cycle unlock word that enables register-based power control. After that it visits each selected domain in ascending index order. For each domain it drives a seven-bit control word and an L1 memory power-down request. It waits for the L1 acknowledge before it asserts reset. It then waits until the domain reads off in both power-status vectors before it moves to the next domain.

Each step changes exactly one control bit and takes one clock cycle, so a neighbour sees every transition on its own. The power-status and acknowledge inputs come from the power switches and from the L1 memory controller, which lie outside the block. Power-up is not handled. A domain that has been turned off keeps its off word until reset.

States, in visiting order: `ST_IDLE` goes to `ST_UNLOCK` on start. `ST_UNLOCK` goes to `ST_PICK`. `ST_PICK` goes to `ST_ISO` while a selected domain is still pending, and to `ST_DONE` when none is left. The per-domain chain is `ST_ISO`, `ST_SRCK`, `ST_SRISO`, `ST_L1REQ`, then `ST_L1WAIT`, which holds until the acknowledge arrives. It continues with `ST_RST`, `ST_CKOFF`, `ST_PON_OFF`, `ST_PON2_OFF`, then `ST_STAWAIT`, which holds until the domain reads off and then returns to `ST_PICK`. `ST_DONE` goes back to `ST_IDLE`.

Top module: `pd_shutdown_seq`

## Requirements
- R1: After reset every control word is 7'h4D, every L1 request is low, and busy, done and the unlock strobe are low. The control bit positions are: 0 active-low reset, 1 isolation, 2 primary power enable, 3 secondary power enable, 4 clock disable, 5 SRAM clock isolation, 6 active-low SRAM isolation.
- R2: An accepted start produces exactly one unlock strobe cycle. During that cycle the unlock word is {UNLOCK_KEY, 16'h0001}. No control bit or L1 request changes before the strobe.
- R3: For a selected domain, the bit changes occur in this order, one per cycle: bit 1 set, bit 5 set, bit 6 cleared, L1 request set, bit 0 cleared, bit 4 set, bit 2 cleared, bit 3 cleared.
- R4: While the domain's L1 acknowledge is low after its request, the control word holds 7'h2F, the reset bit stays high and the block stays busy.
- R5: Once the acknowledge is seen, the remaining four steps complete. The final word of a handled domain is 7'h32 and its L1 request remains high.
- R6: The block does not leave a domain until status bit STA_BASE+d is low in both the primary and the secondary status vectors. With the defaults, domains 0, 1 and 2 use bits 10, 11 and 12.
- R7: Selected domains are handled strictly in ascending index order, each one finishing before the next begins. A domain whose mask bit is clear keeps 7'h4D and its request stays low.
- R8: Done is a single-cycle pulse issued after the last selected domain reads off. Busy is then low. An empty mask still yields one done pulse.
- R9: A start pulse that arrives while busy has no effect: its mask selects nothing and no second done pulse follows.
- R10: Across all control words and L1 requests, at most one bit changes in any clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a shutdown run |
| dom_mask_i | input | N_DOM | Domains to turn off, sampled with start_i |
| l1_ack_i | input | N_DOM | Per-domain L1 power-down acknowledge |
| pwr_sta_i | input | STA_W | Primary power-status vector |
| pwr_sta2_i | input | STA_W | Secondary power-status vector |
| ctrl_o | output | N_DOM*7 | Control words, domain d at bits [7d+6:7d] |
| l1_req_o | output | N_DOM | Per-domain L1 power-down request |
| cfg_we_o | output | 1 | Unlock word strobe |
| cfg_o | output | 32 | Unlock word, zero outside the strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Run finished pulse |

## Verification
The bench holds back the L1 acknowledge and checks two things during the hold. A design that raced ahead would drop reset or start the clock disable while the L1 memory is still in use. The bench also keeps a domain's secondary status high while its primary status is low. A sequencer that tested only one vector would start the next domain early or signal done early. Sparse masks and an empty mask catch skip logic that touches unselected domains or hangs when nothing is selected. A second start fired mid-run catches a sequencer that reloads its mask while busy. A per-cycle monitor flags two bits moving together and any change in the order of the eight steps.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

    localparam int CW_W      = 7;
    localparam int B_RSTN    = 0;
    localparam int B_ISO     = 1;
    localparam int B_PON     = 2;
    localparam int B_PON2    = 3;
    localparam int B_CKOFF   = 4;
    localparam int B_SRCKISO = 5;
    localparam int B_SRISON  = 6;

    // powered-up word: reset released, both switches on, SRAM not isolated
    localparam logic [CW_W-1:0] CW_ON = 7'b100_1101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNLOCK,
        ST_PICK,
        ST_ISO,
        ST_SRCK,
        ST_SRISO,
        ST_L1REQ,
        ST_L1WAIT,
        ST_RST,
        ST_CKOFF,
        ST_PON_OFF,
        ST_PON2_OFF,
        ST_STAWAIT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ISO,
        OP_SRCK,
        OP_SRISO,
        OP_L1,
        OP_RST,
        OP_CKOFF,
        OP_PON,
        OP_PON2
    } step_op_e;

endpackage

// File: rtl/pd_pick.sv
module pd_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // lowest pending index wins, giving ascending service order
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pd_ctrl_bank.sv
module pd_ctrl_bank
    import pd_seq_pkg::*;
#(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_op_e          op_i,
    input  logic [IW-1:0]     sel_i,
    output logic [N*CW_W-1:0] ctrl_o,
    output logic [N-1:0]      l1_req_o
);
    for (genvar g = 0; g < N; g++) begin : g_dom
        logic [CW_W-1:0] word_q;
        logic            l1_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= CW_ON;
                l1_q   <= 1'b0;
            end else if (sel_i == IW'(g)) begin
                case (op_i)
                    OP_ISO:   word_q[B_ISO]     <= 1'b1;
                    OP_SRCK:  word_q[B_SRCKISO] <= 1'b1;
                    OP_SRISO: word_q[B_SRISON]  <= 1'b0;
                    OP_L1:    l1_q              <= 1'b1;
                    OP_RST:   word_q[B_RSTN]    <= 1'b0;
                    OP_CKOFF: word_q[B_CKOFF]   <= 1'b1;
                    OP_PON:   word_q[B_PON]     <= 1'b0;
                    OP_PON2:  word_q[B_PON2]    <= 1'b0;
                    default:  ;
                endcase
            end
        end

        assign ctrl_o[g*CW_W +: CW_W] = word_q;
        assign l1_req_o[g]            = l1_q;
    end
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
    import pd_seq_pkg::*;
#(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [N-1:0]  mask_i,
    input  logic [N-1:0]  ack_i,
    input  logic [N-1:0]  off_i,
    output step_op_e      op_o,
    output logic [IW-1:0] sel_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          unlock_o
);
    seq_state_e    state_q, state_d;
    logic [N-1:0]  pend_q;
    logic [IW-1:0] cur_q;
    logic          any_pend;
    logic [IW-1:0] nxt_idx;

    pd_pick #(.N(N), .IW(IW)) u_pick (
        .req_i   (pend_q),
        .found_o (any_pend),
        .idx_o   (nxt_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_UNLOCK;
            ST_UNLOCK:   state_d = ST_PICK;
            ST_PICK:     state_d = any_pend ? ST_ISO : ST_DONE;
            ST_ISO:      state_d = ST_SRCK;
            ST_SRCK:     state_d = ST_SRISO;
            ST_SRISO:    state_d = ST_L1REQ;
            ST_L1REQ:    state_d = ST_L1WAIT;
            ST_L1WAIT:   if (ack_i[cur_q]) state_d = ST_RST;
            ST_RST:      state_d = ST_CKOFF;
            ST_CKOFF:    state_d = ST_PON_OFF;
            ST_PON_OFF:  state_d = ST_PON2_OFF;
            ST_PON2_OFF: state_d = ST_STAWAIT;
            ST_STAWAIT:  if (off_i[cur_q]) state_d = ST_PICK;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i)
                pend_q <= mask_i;
            if (state_q == ST_PICK && any_pend)
                cur_q <= nxt_idx;
            if (state_q == ST_STAWAIT && off_i[cur_q])
                pend_q[cur_q] <= 1'b0;
        end
    end

    always_comb begin
        op_o     = OP_NONE;
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_DONE);
        unlock_o = (state_q == ST_UNLOCK);
        unique case (state_q)
            ST_ISO:      op_o = OP_ISO;
            ST_SRCK:     op_o = OP_SRCK;
            ST_SRISO:    op_o = OP_SRISO;
            ST_L1REQ:    op_o = OP_L1;
            ST_RST:      op_o = OP_RST;
            ST_CKOFF:    op_o = OP_CKOFF;
            ST_PON_OFF:  op_o = OP_PON;
            ST_PON2_OFF: op_o = OP_PON2;
            default:     op_o = OP_NONE;
        endcase
    end

    assign sel_o = cur_q;
endmodule

// File: rtl/pd_shutdown_seq.sv
module pd_shutdown_seq
    import pd_seq_pkg::*;
#(
    parameter int          N_DOM      = 3,
    parameter int          STA_W      = 32,
    parameter int          STA_BASE   = 10,
    parameter logic [15:0] UNLOCK_KEY = 16'hC3A5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [N_DOM-1:0]     dom_mask_i,
    input  logic [N_DOM-1:0]     l1_ack_i,
    input  logic [STA_W-1:0]     pwr_sta_i,
    input  logic [STA_W-1:0]     pwr_sta2_i,
    output logic [N_DOM*7-1:0]   ctrl_o,
    output logic [N_DOM-1:0]     l1_req_o,
    output logic                 cfg_we_o,
    output logic [31:0]          cfg_o,
    output logic                 busy_o,
    output logic                 done_o
);
    localparam int IW = (N_DOM > 1) ? $clog2(N_DOM) : 1;

    step_op_e      op;
    logic [IW-1:0] sel;
    logic [N_DOM-1:0] dom_off;

    for (genvar d = 0; d < N_DOM; d++) begin : g_off
        assign dom_off[d] = ~pwr_sta_i[STA_BASE + d] & ~pwr_sta2_i[STA_BASE + d];
    end

    pd_seq_fsm #(.N(N_DOM), .IW(IW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .mask_i   (dom_mask_i),
        .ack_i    (l1_ack_i),
        .off_i    (dom_off),
        .op_o     (op),
        .sel_o    (sel),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .unlock_o (cfg_we_o)
    );

    pd_ctrl_bank #(.N(N_DOM), .IW(IW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .sel_i    (sel),
        .ctrl_o   (ctrl_o),
        .l1_req_o (l1_req_o)
    );

    assign cfg_o = cfg_we_o ? {UNLOCK_KEY, 16'h0001} : 32'h0;
endmodule

// File: rtl/pd_seq_chk.sv
module pd_seq_chk #(
    parameter int N_DOM = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_DOM*7-1:0] ctrl_o,
    input logic [N_DOM-1:0]   l1_req_o,
    input logic [N_DOM-1:0]   l1_ack_i,
    input logic               cfg_we_o,
    input logic               done_o
);
    // R10
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ctrl_o ^ $past(ctrl_o)) + $countones(l1_req_o ^ $past(l1_req_o))) <= 1);

    // R2
    unlock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_o |=> !cfg_we_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        // R4
        rst_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ctrl_o[d*7]) |-> (l1_req_o[d] && $past(l1_ack_i[d])));
        // R3
        sram_iso_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ctrl_o[d*7+6]) |-> (ctrl_o[d*7+5] && ctrl_o[d*7+1]));
        // R5
        pwr2_after_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ctrl_o[d*7+3]) |-> !ctrl_o[d*7+2]);
    end
endmodule

bind pd_shutdown_seq pd_seq_chk #(.N_DOM(N_DOM)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_o   (ctrl_o),
    .l1_req_o (l1_req_o),
    .l1_ack_i (l1_ack_i),
    .cfg_we_o (cfg_we_o),
    .done_o   (done_o)
);

// File: tb/pd_shutdown_seq_bench.sv
module pd_shutdown_seq_bench;
    localparam int N = 3;
    localparam logic [15:0] KEY = 16'hC3A5;
    localparam logic [31:0] EXP_CFG = {KEY, 16'h0001};
    localparam logic [6:0] W_ON = 7'h4D, W_OFF = 7'h32, W_HOLD = 7'h2F;
    localparam int SEQ[8] = '{1, 5, 6, 7, 0, 4, 2, 3};
    // {mask[10:8], count[7:6], order0[5:4], order1[3:2], order2[1:0]}
    localparam logic [10:0] VEC[7] = '{
        {3'b111, 2'd3, 2'd0, 2'd1, 2'd2},
        {3'b001, 2'd1, 2'd0, 2'd0, 2'd0},
        {3'b010, 2'd1, 2'd1, 2'd0, 2'd0},
        {3'b100, 2'd1, 2'd2, 2'd0, 2'd0},
        {3'b101, 2'd2, 2'd0, 2'd2, 2'd0},
        {3'b110, 2'd2, 2'd1, 2'd2, 2'd0},
        {3'b000, 2'd0, 2'd0, 2'd0, 2'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [N-1:0] mask = '0, l1_ack, l1_req;
    logic [31:0] pwr_sta, pwr_sta2, cfg;
    logic [N*7-1:0] ctrl;
    logic cfg_we, busy, done;
    logic ack_en = 1'b1;
    logic [N-1:0] hold2 = '0;
    logic [N-1:0] pon_v, pon2_v;

    int total = 0, bad = 0, cyc = 0;
    int ev[N][8];
    int nev[N];
    int order[N];
    int nord, early, multi, ncfg, ndone;
    logic [31:0] cfg_val;
    logic [N*7-1:0] prev_ctrl;
    logic [N-1:0] prev_l1;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    pd_shutdown_seq u_pd_shutdown_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dom_mask_i(mask),
        .l1_ack_i(l1_ack), .pwr_sta_i(pwr_sta), .pwr_sta2_i(pwr_sta2),
        .ctrl_o(ctrl), .l1_req_o(l1_req), .cfg_we_o(cfg_we), .cfg_o(cfg),
        .busy_o(busy), .done_o(done)
    );

    // environment model: switches follow their enables, L1 acks its request
    always_comb begin
        for (int d = 0; d < N; d++) begin
            pon_v[d]  = ctrl[d*7+2];
            pon2_v[d] = ctrl[d*7+3] | hold2[d];
        end
    end
    assign pwr_sta  = 32'(pon_v) << 10;
    assign pwr_sta2 = 32'(pon2_v) << 10;
    assign l1_ack   = l1_req & {N{ack_en}};

    function automatic logic [6:0] cw(input int d);
        return ctrl[d*7 +: 7];
    endfunction

    task automatic clear_mon();
        for (int d = 0; d < N; d++) begin
            nev[d] = 0; order[d] = 0;
            for (int k = 0; k < 8; k++) ev[d][k] = -1;
        end
        nord = 0; early = 0; multi = 0; ncfg = 0; ndone = 0; cfg_val = '0;
        prev_ctrl = {N{W_ON}}; prev_l1 = '0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            int nchg;
            nchg = 0;
            if (cfg_we) begin ncfg++; cfg_val = cfg; end
            if (done) ndone++;
            for (int d = 0; d < N; d++) begin
                for (int b = 0; b < 8; b++) begin
                    logic chg;
                    chg = (b < 7) ? (ctrl[d*7+b] != prev_ctrl[d*7+b]) : (l1_req[d] != prev_l1[d]);
                    if (chg) begin
                        nchg++;
                        if (ncfg == 0) early++;
                        if (nev[d] == 0 && nord < N) begin order[nord] = d; nord++; end
                        if (nev[d] < 8) ev[d][nev[d]] = b;
                        nev[d]++;
                    end
                end
            end
            if (nchg > 1) multi++;
            prev_ctrl = ctrl;
            prev_l1 = l1_req;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; ack_en = 1'b1; hold2 = '0;
        repeat (3) @(negedge clk);
        clear_mon();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic fire(input logic [N-1:0] m);
        @(negedge clk);
        start = 1'b1; mask = m;
        @(negedge clk);
        start = 1'b0; mask = '0;
    endtask

    task automatic wait_done(input int lim);
        int n;
        n = 0;
        while (!done && n < lim) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk(ctrl == {N{W_ON}}, "R1 ctrl", 32'(ctrl), 32'({N{W_ON}}));
        chk(l1_req == '0 && !busy && !done && !cfg_we, "R1 flags", {l1_req, busy, done, cfg_we}, 32'h0);

        foreach (VEC[i]) begin
            logic [2:0] m;
            int cnt;
            m = VEC[i][10:8];
            cnt = int'(VEC[i][7:6]);
            do_reset();
            fire(m);
            wait_done(400);
            chk(ndone == 1, "R8 one done", ndone, 1);
            chk(!busy, "R8 idle after done", busy, 0);
            chk(ncfg == 1 && cfg_val == EXP_CFG, "R2 unlock word", cfg_val, EXP_CFG);
            chk(early == 0, "R2 no early change", early, 0);
            chk(multi == 0, "R10 single bit per cycle", multi, 0);
            chk(nord == cnt, "R7 domain count", nord, cnt);
            for (int k = 0; k < cnt; k++) begin
                int e;
                e = int'(VEC[i][5-2*k -: 2]);
                chk(order[k] == e, "R7 ascending order", order[k], e);
            end
            for (int d = 0; d < N; d++) begin
                if (m[d]) begin
                    logic ok;
                    ok = (nev[d] == 8);
                    for (int k = 0; k < 8; k++) if (ev[d][k] != SEQ[k]) ok = 1'b0;
                    chk(ok, "R3 step order", nev[d], 8);
                    chk(cw(d) == W_OFF && l1_req[d], "R5 final word", {l1_req[d], cw(d)}, {1'b1, W_OFF});
                end else begin
                    chk(cw(d) == W_ON && !l1_req[d], "R7 skipped untouched", {l1_req[d], cw(d)}, {1'b0, W_ON});
                end
            end
        end

        // R4 acknowledge withheld
        do_reset();
        ack_en = 1'b0;
        fire(3'b001);
        repeat (30) @(negedge clk);
        chk(cw(0) == W_HOLD && l1_req[0], "R4 held before ack", {l1_req[0], cw(0)}, {1'b1, W_HOLD});
        chk(busy && ndone == 0, "R4 still busy", busy, 1);
        ack_en = 1'b1;
        wait_done(100);
        chk(cw(0) == W_OFF, "R5 completes after ack", cw(0), W_OFF);

        // R6 secondary status still high
        do_reset();
        hold2 = 3'b001;
        fire(3'b011);
        repeat (40) @(negedge clk);
        chk(ndone == 0 && busy, "R6 waits on secondary status", ndone, 0);
        chk(cw(1) == W_ON && !l1_req[1], "R6 next domain not started", cw(1), W_ON);
        hold2 = '0;
        wait_done(100);
        chk(cw(1) == W_OFF && ndone == 1, "R6 proceeds when off", cw(1), W_OFF);

        // R9 start while busy
        do_reset();
        fire(3'b001);
        repeat (4) @(negedge clk);
        fire(3'b110);
        wait_done(200);
        repeat (20) @(negedge clk);
        chk(cw(1) == W_ON && cw(2) == W_ON, "R9 busy start ignored", {cw(2), cw(1)}, {W_ON, W_ON});
        chk(ndone == 1 && ncfg == 1, "R9 single run", ndone, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule